// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target Controller

This block is the bus-facing state machine of a two-wire (I2C) serial EEPROM holding 8192 bytes. It takes SCL and SDA samples that have already been brought into the system clock domain. It pulls the shared data line low through a single open-drain enable. It finds START and STOP conditions and checks the device address against three strap inputs. For writes it collects a two-byte memory address and hands each data byte to a page buffer, one pulse per byte. For reads it fetches bytes from a synchronous memory read port and shifts them out most significant bit first.

The memory array and the page buffer sit outside the block. The page buffer reports a running internal programming cycle on a busy input. While busy is high the controller acknowledges nothing, so a host can poll the device until its address is acknowledged again. The read pointer runs across the whole array and wraps from the last byte back to zero. The write pointer stays inside its 32-byte page.

Top module: `i2cmem_target`

## Requirements
- R1: A START (SDA falling while SCL is high) begins device-address reception from any state, abandoning any partial byte. A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R2: The block acknowledges an address byte only when its upper seven bits equal binary 1010 followed by `strap_addr[2:0]`. Bit 0 selects the direction (1 = read, 0 = write). After a mismatch it acknowledges nothing until the next START.
- R3: An acknowledge holds `sda_oe` high from the SCL falling edge that ends bit 8 until the SCL falling edge that ends bit 9. `sda_oe` only changes while SCL is low.
- R4: A write command is followed by two address bytes, high byte first. The memory address is the low 5 bits of the high byte joined with the low byte, and bits 7..5 of the high byte are ignored.
- R5: Each acknowledged write data byte produces one `wr_en` pulse carrying `wr_addr` and `wr_data`. The address then advances by one, with its low 5 bits wrapping inside the 32-byte page and its upper bits unchanged.
- R6: A STOP after at least one acknowledged write data byte pulses `wr_commit` once. A STOP after an address-only write, or a transfer ended by a repeated START, gives no pulse.
- R7: While `wr_busy` is high, no byte is acknowledged, including a matching device address, and no `wr_en` is issued.
- R8: A read command with no preceding address returns the byte at the internal pointer. The pointer rests one past the last byte written or read.
- R9: A write command with two address bytes, then a repeated START and a read command, returns data starting at the loaded address.
- R10: After each byte sent, a host ACK makes the block send the byte at the next address, wrapping from 8191 to 0. A host NoACK makes it release SDA and stay silent until a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA bus level |
| strap_addr | input | 3 | Strapped low device-address bits |
| wr_busy | input | 1 | Internal programming cycle in progress |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| rd_en | output | 1 | Memory read request, one cycle |
| rd_addr | output | ADDR_W | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| wr_en | output | 1 | Write data byte to page buffer, one cycle |
| wr_addr | output | ADDR_W | Page buffer byte address |
| wr_data | output | 8 | Page buffer byte |
| wr_commit | output | 1 | Start programming the loaded page, one cycle |

## Verification
Each SCL or SDA change is seen in the clock cycle it arrives. `sda_oe` therefore settles on the first clock edge after the SCL falling edge that calls for it. A read byte is in the shift register two edges after its `rd_en`, well before the next falling edge. `wr_en` and `wr_commit` rise one edge after the SCL or SDA event that causes them. The bench model of the host holds each SCL level for at least four clocks and samples SDA at the middle of the SCL high time. It therefore reads every acknowledge and data bit after the design's register update has settled. Write pulses and commits are sampled on the falling clock edge and compared in order against a queue of expected address and data pairs.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    localparam logic [3:0] DEV_ID = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WRDATA,
        ST_RDDATA,
        ST_WAIT_STOP
    } bus_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } bus_evt_t;

    typedef struct packed {
        logic       ok;
        bus_state_e nxt;
    } ack_plan_t;

    function automatic logic dev_hit(input logic [7:0] b, input logic [2:0] strap);
        return b[7:1] == {DEV_ID, strap};
    endfunction

endpackage

// File: rtl/i2cmem_bus_events.sv
module i2cmem_bus_events
    import i2cmem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output bus_evt_t evt
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    always_comb begin
        evt.scl_rise = scl_in & ~scl_q;
        evt.scl_fall = ~scl_in & scl_q;
        evt.start    = scl_in & scl_q & sda_q & ~sda_in;
        evt.stop     = scl_in & scl_q & ~sda_q & sda_in;
    end

endmodule

// File: rtl/i2cmem_addr_ptr.sv
module i2cmem_addr_ptr #(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step_seq,
    input  logic              step_page,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] ptr_seq
);
    logic [ADDR_W-1:0] ptr_page;

    assign ptr_seq = ptr + 1'b1;

    generate
        if (PAGE_W < ADDR_W) begin : g_paged
            logic [PAGE_W-1:0] low_inc;
            assign low_inc  = ptr[PAGE_W-1:0] + 1'b1;
            assign ptr_page = {ptr[ADDR_W-1:PAGE_W], low_inc};

            // R5: a page step never leaves the current page
            assert_page_stay_R5: assert property (@(posedge clk) disable iff (rst)
                (step_page && !load) |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])));
        end else begin : g_flat
            assign ptr_page = ptr_seq;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)            ptr <= '0;
        else if (load)      ptr <= load_val;
        else if (step_page) ptr <= ptr_page;
        else if (step_seq)  ptr <= ptr_seq;
    end

    // R10: sequential stepping wraps from the top address to zero
    assert_seq_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (step_seq && !load && !step_page && (&ptr)) |=> (ptr == '0));

endmodule

// File: rtl/i2cmem_target.sv
module i2cmem_target
    import i2cmem_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [2:0]        strap_addr,
    input  logic              wr_busy,
    output logic              sda_oe,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);
    localparam int HI_W  = ADDR_W - 8;
    localparam int CNT_W = 4;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(8);

    bus_evt_t          evt;
    bus_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic              in_ack;
    logic [7:0]        shreg;
    logic [7:0]        tx;
    logic [HI_W-1:0]   hi_q;
    ack_plan_t         plan, plan_q;
    logic              mack_q;
    logic              fetch_q;
    logic              wr_any;
    logic              active;
    logic              ack_entry;
    logic              ld, step_seq, step_page;
    logic [ADDR_W-1:0] ptr, ptr_seq;

    i2cmem_bus_events u_events (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .evt    (evt)
    );

    i2cmem_addr_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (ld),
        .load_val  ({hi_q, shreg}),
        .step_seq  (step_seq),
        .step_page (step_page),
        .ptr       (ptr),
        .ptr_seq   (ptr_seq)
    );

    assign active    = (state != ST_IDLE) && (state != ST_WAIT_STOP);
    assign ack_entry = active && !evt.start && !evt.stop && evt.scl_fall
                       && !in_ack && (bit_cnt == LAST_BIT);

    // Acknowledge decision for the byte just completed
    always_comb begin
        plan      = '{ok: 1'b0, nxt: ST_WAIT_STOP};
        ld        = 1'b0;
        step_seq  = 1'b0;
        step_page = 1'b0;
        case (state)
            ST_DEVADDR: begin
                plan.ok  = dev_hit(shreg, strap_addr) && !wr_busy;
                plan.nxt = shreg[0] ? ST_RDDATA : ST_ADDR_HI;
            end
            ST_ADDR_HI: plan = '{ok: !wr_busy, nxt: ST_ADDR_LO};
            ST_ADDR_LO: plan = '{ok: !wr_busy, nxt: ST_WRDATA};
            ST_WRDATA:  plan = '{ok: !wr_busy, nxt: ST_WRDATA};
            ST_RDDATA:  plan = '{ok: 1'b0, nxt: ST_RDDATA};
            default:    plan = '{ok: 1'b0, nxt: ST_WAIT_STOP};
        endcase
        if (ack_entry) begin
            ld        = (state == ST_ADDR_LO) && plan.ok;
            step_page = (state == ST_WRDATA) && plan.ok;
            step_seq  = (state == ST_RDDATA);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            in_ack    <= 1'b0;
            shreg     <= '0;
            tx        <= 8'hFF;
            hi_q      <= '0;
            plan_q    <= '{ok: 1'b0, nxt: ST_IDLE};
            mack_q    <= 1'b0;
            fetch_q   <= 1'b0;
            wr_any    <= 1'b0;
            sda_oe    <= 1'b0;
            rd_en     <= 1'b0;
            rd_addr   <= '0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            rd_en     <= 1'b0;
            wr_en     <= 1'b0;
            wr_commit <= 1'b0;
            fetch_q   <= rd_en;
            if (fetch_q) tx <= rd_data;

            if (evt.stop) begin
                state     <= ST_IDLE;
                in_ack    <= 1'b0;
                bit_cnt   <= '0;
                sda_oe    <= 1'b0;
                wr_commit <= wr_any;
                wr_any    <= 1'b0;
            end else if (evt.start) begin
                state   <= ST_DEVADDR;
                in_ack  <= 1'b0;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
                wr_any  <= 1'b0;
            end else if (active) begin
                if (evt.scl_rise) begin
                    if (in_ack) begin
                        mack_q <= ~sda_in;
                    end else if (bit_cnt != LAST_BIT) begin
                        shreg   <= {shreg[6:0], sda_in};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                if (evt.scl_fall) begin
                    if (in_ack) begin
                        in_ack  <= 1'b0;
                        bit_cnt <= '0;
                        if (state == ST_RDDATA) begin
                            if (mack_q) begin
                                sda_oe <= ~tx[7];
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WAIT_STOP;
                            end
                        end else if (plan_q.ok) begin
                            state  <= plan_q.nxt;
                            sda_oe <= (plan_q.nxt == ST_RDDATA) ? ~tx[7] : 1'b0;
                        end else begin
                            state  <= ST_WAIT_STOP;
                            sda_oe <= 1'b0;
                        end
                    end else if (bit_cnt == LAST_BIT) begin
                        in_ack <= 1'b1;
                        plan_q <= plan;
                        sda_oe <= plan.ok;
                        mack_q <= 1'b0;
                        case (state)
                            ST_DEVADDR: if (plan.ok && shreg[0]) begin
                                rd_en   <= 1'b1;
                                rd_addr <= ptr;
                            end
                            ST_ADDR_HI: if (plan.ok) hi_q <= shreg[HI_W-1:0];
                            ST_WRDATA: if (plan.ok) begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                wr_any  <= 1'b1;
                            end
                            ST_RDDATA: begin
                                rd_en   <= 1'b1;
                                rd_addr <= ptr_seq;
                            end
                            default: ;
                        endcase
                    end else if (state == ST_RDDATA) begin
                        tx     <= {tx[6:0], 1'b1};
                        sda_oe <= ~tx[6];
                    end
                end
            end
        end
    end

    // R1: idle means the data line is released
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe);

    // R3: the data line driver only moves while SCL is low
    assert_oe_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl_in));

    // R7: no acknowledge is started while busy
    assert_no_ack_busy_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(sda_oe) && in_ack) |-> !$past(wr_busy));

    // R7: no page-buffer write while busy
    assert_no_write_busy_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !$past(wr_busy));

    // R6: commit only follows a STOP condition
    assert_commit_on_stop_R6: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> $past(evt.stop));

    // R5: memory-side pulses never overlap
    assert_pulse_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_en, wr_en, wr_commit}));

endmodule

// File: tb/i2cmem_target_bench.sv
module i2cmem_target_bench;
    localparam int CLK_P    = 10;
    localparam int Q        = 4;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        busy = 1'b0;
    logic [2:0]  strap = 3'b101;
    logic        sda_bus;
    logic        sda_oe, rd_en, wr_en, wr_commit;
    logic [12:0] rd_addr, wr_addr;
    logic [7:0]  rd_data = 8'h00;
    logic [7:0]  wr_data;

    int checks = 0;
    int fails = 0;
    int commits = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [20:0] exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2cmem_target u_i2cmem_target (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_m),
        .sda_in     (sda_bus),
        .strap_addr (strap),
        .wr_busy    (busy),
        .sda_oe     (sda_oe),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_commit  (wr_commit)
    );

    function automatic logic [7:0] pat(input logic [12:0] a);
        return a[7:0] ^ {3'b101, a[12:8]};
    endfunction

    always @(posedge clk) if (rd_en) rd_data <= pat(rd_addr);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor for page-buffer writes and commits
    always @(negedge clk) begin : mon
        logic [20:0] e;
        if (!rst && wr_en) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R5 unexpected write actual=%h expected=none", {wr_addr, wr_data});
            end else begin
                e = exp_q.pop_front();
                if ({wr_addr, wr_data} !== e) begin
                    fails++;
                    $display("FAIL R5 write actual=%h expected=%h", {wr_addr, wr_data}, e);
                end
            end
        end
        if (!rst && wr_commit) commits++;
    end

    always @(negedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start;
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic m_wbit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2*Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_rbit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus;  tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic m_send(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_wbit(v[i]);
        m_rbit(b);
        ack = ~b;
    endtask

    task automatic m_recv(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            v[i] = b;
        end
        m_wbit(~mack);
    endtask

    initial begin
        logic       ack;
        logic       b;
        logic [7:0] v;
        int         c0;

        tick(5);
        rst = 1'b0;
        tick(2);
        chk("R1 reset sda_oe", int'(sda_oe), 0);
        chk("R6 reset commit", int'(wr_commit), 0);

        // Page write with wrap inside the page, junk in high address bits
        m_start;
        m_send({4'hA, strap, 1'b0}, ack); chk("R2 own write address acked", int'(ack), 1);
        m_send(8'hE1, ack);               chk("R4 high address byte acked", int'(ack), 1);
        m_send(8'h3E, ack);               chk("R4 low address byte acked", int'(ack), 1);
        tick(2);
        chk("R3 SDA released after acknowledge", int'(sda_oe), 0);
        exp_q.push_back({13'h013E, 8'h11});
        m_send(8'h11, ack); chk("R5 data byte 0 acked", int'(ack), 1);
        exp_q.push_back({13'h013F, 8'h22});
        m_send(8'h22, ack); chk("R5 data byte 1 acked", int'(ack), 1);
        exp_q.push_back({13'h0120, 8'h33});
        m_send(8'h33, ack); chk("R5 data byte 2 acked after page wrap", int'(ack), 1);
        c0 = commits;
        m_stop;
        tick(4);
        chk("R6 one commit after STOP", commits - c0, 1);
        chk("R5 all expected writes seen", exp_q.size(), 0);

        // Current-address read, then NoACK behaviour
        m_start;
        m_send({4'hA, strap, 1'b1}, ack); chk("R2 own read address acked", int'(ack), 1);
        m_recv(1'b0, v);
        chk("R8 current address read", int'(v), int'(pat(13'h0121)));
        tick(2);
        chk("R10 SDA released after NoACK", int'(sda_oe), 0);
        m_rbit(b);
        chk("R10 silent until STOP", int'(b), 1);
        m_stop;

        // Random read then sequential read across the top of memory
        c0 = commits;
        m_start;
        m_send({4'hA, strap, 1'b0}, ack); chk("R9 write command acked", int'(ack), 1);
        m_send(8'h1F, ack);
        m_send(8'hFE, ack);               chk("R9 address acked", int'(ack), 1);
        m_start;
        m_send({4'hA, strap, 1'b1}, ack); chk("R9 read after repeated START acked", int'(ack), 1);
        m_recv(1'b1, v); chk("R9 random read first byte", int'(v), int'(pat(13'h1FFE)));
        m_recv(1'b1, v); chk("R10 sequential byte at top", int'(v), int'(pat(13'h1FFF)));
        m_recv(1'b1, v); chk("R10 sequential wrap to zero", int'(v), int'(pat(13'h0000)));
        m_recv(1'b0, v); chk("R10 sequential after wrap", int'(v), int'(pat(13'h0001)));
        m_stop;
        tick(4);
        chk("R6 no commit without data", commits - c0, 0);

        // Address mismatch
        m_start;
        m_send({4'hA, 3'b000, 1'b0}, ack); chk("R2 strap mismatch not acked", int'(ack), 0);
        m_send(8'h00, ack);                chk("R2 bytes ignored after mismatch", int'(ack), 0);
        m_stop;
        m_start;
        m_send({4'hB, strap, 1'b1}, ack);  chk("R2 wrong prefix not acked", int'(ack), 0);
        m_stop;

        // Busy polling
        busy = 1'b1;
        m_start;
        m_send({4'hA, strap, 1'b0}, ack); chk("R7 own address not acked while busy", int'(ack), 0);
        m_stop;
        busy = 1'b0;
        m_start;
        m_send({4'hA, strap, 1'b0}, ack); chk("R7 acked once idle", int'(ack), 1);
        m_send(8'h00, ack);
        busy = 1'b1;
        m_send(8'h55, ack);               chk("R7 address byte not acked when busy", int'(ack), 0);
        m_stop;
        busy = 1'b0;

        // Repeated START in the middle of a data byte
        c0 = commits;
        m_start;
        m_send({4'hA, strap, 1'b0}, ack);
        m_send(8'h00, ack);
        m_send(8'h40, ack);               chk("R1 address load acked", int'(ack), 1);
        for (int i = 0; i < 4; i++) m_wbit(1'b0);
        m_start;
        m_send({4'hA, strap, 1'b1}, ack); chk("R1 address accepted after abort", int'(ack), 1);
        m_recv(1'b0, v);
        chk("R1 aborted byte left pointer", int'(v), int'(pat(13'h0040)));
        m_stop;
        tick(4);
        chk("R6 no commit for aborted byte", commits - c0, 0);
        chk("R5 no stray writes", exp_q.size(), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule